// File: doc/BRIEF.md
# Shared Converter Arbiter with Preemption

This block shares one analog-to-digital converter among three requesters: a radio power-detect controller (index 0), a low-power always-on controller (index 1) and a digital sampling controller (index 2). Each requester raises a level request and holds it until the block returns a one-cycle completion pulse together with a result word. The converter itself is modelled as a stub with a fixed latency. It captures the shared analog input sample when a conversion starts and returns it after that latency.

Three arbitration modes are selectable. Fixed mode grants by a programmable priority. In fixed mode, a requester that outranks the current owner takes the converter at once, and the displaced owner is completed early with a result marked invalid. Rotating mode serves requesters in turn. Shield mode turns arbitration off and serves only one selected requester. After every handover, a programmable settle time of zero to four cycles passes before the conversion starts.

Top module: `adc_share_arb`

## Requirements
- R1: After reset, grant and done are zero, result is zero, the priorities are radio 2, low-power 1, digital 0 (prio_cur = 6'h06, two bits per requester with the radio in bits 1:0), and force_vec = 3'b001.
- R2: A priority write updates prio_cur on the next cycle only if the three written values are exactly 0, 1 and 2 in some order. Any other write, including a value of 3, leaves prio_cur unchanged.
- R3: force_vec is always one-hot and marks the requester that currently holds priority 2.
- R4: In fixed mode (arb_mode = 0), an idle arbiter grants the requesting requester with the highest priority. Every request is eventually served once new requests stop.
- R5: In rotating mode (arb_mode = 1), after requester k completes, the search for the next grant starts at requester (k+1) mod 3. After reset, the search starts at requester 0.
- R6: In shield mode (arb_mode = 2), only the requester named by force_sel is granted. Requests from the others get no grant and no done. A force_sel of 3 grants nobody.
- R7: In fixed mode only, a request from a requester that outranks the busy owner (settling or converting) ends the ownership at the next clock edge. The old owner gets done with tag 4'hF and data 0, and the grant moves to the highest-priority requester in that same edge. A request from a lower-priority requester never preempts.
- R8: A valid completion pulses done[i] for exactly one cycle. Its result carries the requester's 4-bit channel (0 to 9, from chan_flat[4i+3:4i]) in bits 16:13, zero in bit 12, and the captured ain in bits 11:0. Every tag above 9 means invalid.
- R9: done rises exactly 1 + S + CONV_LAT cycles after the cycle in which the request was first presented to an idle arbiter. S is settle_cycles clamped to MAX_SETTLE (values above 4 act as 4).
- R10: Rotating mode never preempts. A busy owner finishes with a valid result whatever arrives.
- R11: grant and done are each at most one-hot, and grant names the owner during both settle and conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_mode | input | 2 | 0 fixed, 1 rotating, 2 shield |
| force_sel | input | 2 | Requester served in shield mode (3 = none) |
| settle_cycles | input | 3 | Settle cycles after a handover, clamped to 4 |
| prio_wr | input | 1 | Priority write strobe |
| prio_wdata | input | 6 | New priorities, 2 bits each, radio in bits 1:0 |
| req | input | 3 | Level requests, held until done |
| chan_flat | input | 12 | Channel number of each requester, 4 bits each |
| ain | input | 12 | Analog sample presented to the converter stub |
| grant | output | 3 | One-hot current owner |
| done | output | 3 | One-cycle completion pulse per requester |
| result | output | 17 | Tag in 16:13, zero in 12, data in 11:0 |
| prio_cur | output | 6 | Priorities in force |
| force_vec | output | 3 | One-hot highest-priority requester |

## Verification
The hardest case to reach from the ports is preemption. A higher-priority request has to land while a lower-priority owner is still settling or converting. The bench must then see the invalid completion and the handover in the same cycle, followed by the new owner's full-latency result. Directed cases place the intruding request a fixed number of cycles after a grant, at a point known to fall mid-conversion. Long random runs in fixed mode, with random priority permutations and settle times, raise requests at random so that preemption happens many times. Each invalid completion is checked against the priority of the requester that took the grant.

// File: rtl/adc_arb_pkg.sv
// Shared constants and types for the converter arbiter.
// Assumes exactly three requesters. The result word layout is fixed.
package adc_arb_pkg;
    localparam int NREQ        = 3;
    localparam int IDX_W       = $clog2(NREQ);
    localparam int PRIO_W      = 2;
    localparam int TAG_W       = 4;
    localparam int DATA_W      = 12;
    localparam int RES_W       = TAG_W + 1 + DATA_W;
    localparam logic [TAG_W-1:0] BAD_TAG = 4'hF;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_LOOP   = 2'd1,
        MODE_SHIELD = 2'd2,
        MODE_RSVD   = 2'd3
    } arb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/adc_arb_prio_bank.sv
// Priority register file.
// It accepts a write only when the three values form a permutation of
// 0, 1 and 2, and it derives the one-hot vector of the top requester.
// Assumes prio_wr is a plain synchronous strobe.
module adc_arb_prio_bank
    import adc_arb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prio_wr,
    input  logic [NREQ*PRIO_W-1:0]   prio_wdata,
    output logic [NREQ*PRIO_W-1:0]   prio_flat,
    output logic [NREQ-1:0]          top_vec
);
    logic [PRIO_W-1:0] prio_q [NREQ];
    logic [PRIO_W-1:0] wr_a   [NREQ];
    logic              wr_ok;

    // Unpack the write data into per-requester fields.
    for (genvar i = 0; i < NREQ; i++) begin : g_unpack
        assign wr_a[i] = prio_wdata[i*PRIO_W +: PRIO_W];
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // A write is legal only if the values are in range and pairwise distinct.
    always_comb begin
        wr_ok = 1'b1;
        for (int i = 0; i < NREQ; i++) begin
            if (wr_a[i] > PRIO_W'(NREQ - 1)) wr_ok = 1'b0;
            for (int j = i + 1; j < NREQ; j++) begin
                if (wr_a[i] == wr_a[j]) wr_ok = 1'b0;
            end
        end
    end

    // Hold the priorities, loading the defaults at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREQ; i++) prio_q[i] <= PRIO_W'(NREQ - 1 - i);
        end else if (prio_wr && wr_ok) begin
            for (int i = 0; i < NREQ; i++) prio_q[i] <= wr_a[i];
        end
    end

    // Mark the requester that outranks every other.
    for (genvar i = 0; i < NREQ; i++) begin : g_top
        always_comb begin
            top_vec[i] = 1'b1;
            for (int j = 0; j < NREQ; j++) begin
                if (j != i && prio_q[j] >= prio_q[i]) top_vec[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_arb_select.sv
// Combinational grant selection for the three arbitration modes, plus
// detection of a preempting request in fixed mode.
// Assumes the priorities are distinct.
module adc_arb_select
    import adc_arb_pkg::*;
(
    input  logic [NREQ-1:0]         req,
    input  logic [NREQ*PRIO_W-1:0]  prio_flat,
    input  arb_mode_e               mode,
    input  logic [IDX_W-1:0]        ptr,
    input  logic [IDX_W-1:0]        force_sel,
    input  logic                    busy,
    input  logic [IDX_W-1:0]        owner,
    output logic                    win_ok,
    output logic [IDX_W-1:0]        win_idx,
    output logic                    preempt,
    output logic [IDX_W-1:0]        preempt_idx
);
    logic [PRIO_W-1:0] prio_a [NREQ];
    logic [NREQ-1:0]   beats;
    logic [NREQ-1:0]   outranks;
    logic              fix_ok, loop_ok, sh_ok;
    logic [IDX_W-1:0]  fix_idx, loop_idx;
    logic [PRIO_W-1:0] own_prio;

    for (genvar i = 0; i < NREQ; i++) begin : g_cmp
        assign prio_a[i] = prio_flat[i*PRIO_W +: PRIO_W];

        // Requester i wins if it requests and outranks every other requester.
        always_comb begin
            beats[i] = req[i];
            for (int j = 0; j < NREQ; j++) begin
                if (j != i && req[j] && prio_a[j] >= prio_a[i]) beats[i] = 1'b0;
            end
        end

        // Requester i would displace the present owner.
        assign outranks[i] = req[i] && (IDX_W'(i) != owner) && (prio_a[i] > own_prio);
    end

    // Owner priority lookup.
    always_comb begin
        own_prio = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (IDX_W'(i) == owner) own_prio = prio_a[i];
        end
    end

    // Encode the fixed-priority winner.
    always_comb begin
        fix_ok  = |beats;
        fix_idx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (beats[i]) fix_idx = IDX_W'(i);
        end
    end

    // Rotating search, starting at ptr; the nearest requester wins.
    always_comb begin
        loop_ok  = 1'b0;
        loop_idx = '0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            int s;
            s = int'(ptr) + k;
            if (s >= NREQ) s = s - NREQ;
            if (req[s]) begin
                loop_ok  = 1'b1;
                loop_idx = IDX_W'(s);
            end
        end
    end

    // Shield mode serves only the forced requester.
    always_comb begin
        sh_ok = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (IDX_W'(i) == force_sel && req[i]) sh_ok = 1'b1;
        end
    end

    // Pick the winner for the selected mode.
    always_comb begin
        case (mode)
            MODE_FIXED:  begin win_ok = fix_ok;  win_idx = fix_idx;   end
            MODE_LOOP:   begin win_ok = loop_ok; win_idx = loop_idx;  end
            MODE_SHIELD: begin win_ok = sh_ok;   win_idx = force_sel; end
            default:     begin win_ok = 1'b0;    win_idx = '0;        end
        endcase
    end

    assign preempt     = (mode == MODE_FIXED) && busy && (|outranks);
    assign preempt_idx = fix_idx;
endmodule

// File: rtl/adc_arb_conv_stub.sv
// Fixed-latency converter model.
// It samples the input at start and flags the last cycle of the
// conversion. A start in the same cycle as an abort takes precedence.
// Assumes CONV_LAT >= 1.
module adc_arb_conv_stub
    import adc_arb_pkg::*;
#(
    parameter int CONV_LAT = 8,
    localparam int CNT_W   = $clog2(CONV_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] sample_in,
    output logic              last,
    output logic [DATA_W-1:0] data_out
);
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] smp_q;

    // Count down the conversion time and hold the captured sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            smp_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CONV_LAT);
            smp_q <= sample_in;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last     = (cnt_q == CNT_W'(1));
    assign data_out = smp_q;
endmodule

// File: rtl/adc_share_arb.sv
// Top of the shared converter arbiter.
// It sequences ownership through the idle, settle and conversion phases,
// handles preemption and builds the result word.
// Assumes each requester holds req until it sees its done pulse.
module adc_share_arb
    import adc_arb_pkg::*;
#(
    parameter int CONV_LAT   = 8,
    parameter int MAX_SETTLE = 4,
    localparam int SETTLE_W  = $clog2(MAX_SETTLE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               arb_mode,
    input  logic [1:0]               force_sel,
    input  logic [SETTLE_W-1:0]      settle_cycles,
    input  logic                     prio_wr,
    input  logic [5:0]               prio_wdata,
    input  logic [2:0]               req,
    input  logic [11:0]              chan_flat,
    input  logic [11:0]              ain,
    output logic [2:0]               grant,
    output logic [2:0]               done,
    output logic [16:0]              result,
    output logic [5:0]               prio_cur,
    output logic [2:0]               force_vec
);
    arb_mode_e          mode;
    arb_state_e         st_q, st_n;
    logic [IDX_W-1:0]   own_q, own_n, ptr_q, ptr_n;
    logic [SETTLE_W-1:0] sc_q, sc_n, settle_eff;
    logic [NREQ-1:0]    done_n;
    logic [RES_W-1:0]   res_n;
    logic               start, abort, busy;
    logic               win_ok, preempt, conv_last;
    logic [IDX_W-1:0]   win_idx, pre_idx;
    logic [DATA_W-1:0]  conv_data;
    logic [TAG_W-1:0]   chan_a [NREQ];
    logic [TAG_W-1:0]   own_chan;

    assign mode = arb_mode_e'(arb_mode);
    assign busy = (st_q != ST_IDLE);

    for (genvar i = 0; i < NREQ; i++) begin : g_chan
        assign chan_a[i] = chan_flat[i*TAG_W +: TAG_W];
        assign grant[i]  = busy && (own_q == IDX_W'(i));
    end

    // Channel of the present owner.
    always_comb begin
        own_chan = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (own_q == IDX_W'(i)) own_chan = chan_a[i];
        end
    end

    // Clamp the settle request to the supported maximum.
    assign settle_eff = (settle_cycles > SETTLE_W'(MAX_SETTLE)) ?
                        SETTLE_W'(MAX_SETTLE) : settle_cycles;

    adc_arb_prio_bank u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_wr    (prio_wr),
        .prio_wdata (prio_wdata),
        .prio_flat  (prio_cur),
        .top_vec    (force_vec)
    );

    adc_arb_select u_sel (
        .req         (req),
        .prio_flat   (prio_cur),
        .mode        (mode),
        .ptr         (ptr_q),
        .force_sel   (force_sel),
        .busy        (busy),
        .owner       (own_q),
        .win_ok      (win_ok),
        .win_idx     (win_idx),
        .preempt     (preempt),
        .preempt_idx (pre_idx)
    );

    adc_arb_conv_stub #(.CONV_LAT(CONV_LAT)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .sample_in (ain),
        .last      (conv_last),
        .data_out  (conv_data)
    );

    // Next-state logic for ownership, settle and completion.
    always_comb begin
        st_n   = st_q;
        own_n  = own_q;
        ptr_n  = ptr_q;
        sc_n   = sc_q;
        start  = 1'b0;
        abort  = 1'b0;
        done_n = '0;
        res_n  = '0;
        case (st_q)
            ST_IDLE: begin
                if (win_ok) begin
                    own_n = win_idx;
                    if (settle_eff == '0) begin
                        st_n  = ST_CONV;
                        start = 1'b1;
                    end else begin
                        st_n = ST_SETTLE;
                        sc_n = settle_eff;
                    end
                end
            end
            ST_SETTLE, ST_CONV: begin
                if (preempt) begin
                    abort          = (st_q == ST_CONV);
                    done_n[own_q]  = 1'b1;
                    res_n          = {BAD_TAG, 1'b0, {DATA_W{1'b0}}};
                    own_n          = pre_idx;
                    if (settle_eff == '0) begin
                        st_n  = ST_CONV;
                        start = 1'b1;
                    end else begin
                        st_n = ST_SETTLE;
                        sc_n = settle_eff;
                    end
                end else if (st_q == ST_SETTLE) begin
                    if (sc_q <= SETTLE_W'(1)) begin
                        st_n  = ST_CONV;
                        start = 1'b1;
                        sc_n  = '0;
                    end else begin
                        sc_n = sc_q - 1'b1;
                    end
                end else if (conv_last) begin
                    done_n[own_q] = 1'b1;
                    res_n         = {own_chan, 1'b0, conv_data};
                    st_n          = ST_IDLE;
                    if (mode == MODE_LOOP) begin
                        ptr_n = (own_q == IDX_W'(NREQ - 1)) ? '0 : own_q + 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State, owner, rotation pointer and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            own_q  <= '0;
            ptr_q  <= '0;
            sc_q   <= '0;
            done   <= '0;
            result <= '0;
        end else begin
            st_q   <= st_n;
            own_q  <= own_n;
            ptr_q  <= ptr_n;
            sc_q   <= sc_n;
            done   <= done_n;
            result <= res_n;
        end
    end
endmodule

// File: rtl/adc_share_arb_chk.sv
// Property checker for the shared converter arbiter, bound to the top.
// It observes only the top's ports.
module adc_share_arb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  arb_mode,
    input logic [1:0]  force_sel,
    input logic        prio_wr,
    input logic [2:0]  grant,
    input logic [2:0]  done,
    input logic [16:0] result,
    input logic [5:0]  prio_cur,
    input logic [2:0]  force_vec
);
    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_done_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    assert_force_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(force_vec));

    assert_prio_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_cur[1:0] != prio_cur[3:2]) && (prio_cur[1:0] != prio_cur[5:4]) &&
        (prio_cur[3:2] != prio_cur[5:4]) && (prio_cur[1:0] != 2'd3) &&
        (prio_cur[3:2] != 2'd3) && (prio_cur[5:4] != 2'd3));

    assert_prio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_wr |=> (prio_cur == $past(prio_cur)));

    assert_invalid_only_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done) && result[16:13] == 4'hF) |-> ($past(arb_mode) == 2'd0));

    assert_tag_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> (!result[12] && (result[16:13] <= 4'd9 || result[16:13] == 4'hF)));

    assert_shield_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_mode == 2'd2 && $past(arb_mode) == 2'd2 && $past(grant) == 3'b000 && grant != 3'b000)
        |-> (grant == (3'b001 << force_sel)));
endmodule

bind adc_share_arb adc_share_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_mode  (arb_mode),
    .force_sel (force_sel),
    .prio_wr   (prio_wr),
    .grant     (grant),
    .done      (done),
    .result    (result),
    .prio_cur  (prio_cur),
    .force_vec (force_vec)
);

// File: tb/adc_share_arb_tb.sv
module adc_share_arb_tb;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  arb_mode;
    logic [1:0]  force_sel;
    logic [2:0]  settle_cycles;
    logic        prio_wr;
    logic [5:0]  prio_wdata;
    logic [2:0]  req;
    logic [11:0] chan_flat;
    logic [11:0] ain;
    logic [2:0]  grant, done, force_vec;
    logic [16:0] result;
    logic [5:0]  prio_cur;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [2:0]  seen_done;
    logic [16:0] seen_res;
    int bp [3];

    always #5 clk = ~clk;

    adc_share_arb u_dut (
        .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .force_sel(force_sel),
        .settle_cycles(settle_cycles), .prio_wr(prio_wr), .prio_wdata(prio_wdata),
        .req(req), .chan_flat(chan_flat), .ain(ain), .grant(grant), .done(done),
        .result(result), .prio_cur(prio_cur), .force_vec(force_vec)
    );

    function automatic int chan_of(input int i);
        return (i == 0) ? 3 : (i == 1) ? 7 : 9;
    endfunction

    function automatic int clampS(input int s);
        return (s > 4) ? 4 : s;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One clock: sample at the falling edge and drop served requests.
    task automatic step();
        @(negedge clk);
        cyc++;
        seen_done = done;
        seen_res  = result;
        for (int i = 0; i < 3; i++) if (done[i]) req[i] = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int who);
        who = -1;
        for (int n = 0; n < limit; n++) begin
            step();
            if (|seen_done) begin
                for (int i = 0; i < 3; i++) if (seen_done[i]) who = i;
                return;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; prio_wr = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        bp[0] = 2; bp[1] = 1; bp[2] = 0;
    endtask

    task automatic write_prio(input int p0, input int p1, input int p2);
        prio_wdata = {2'(p2), 2'(p1), 2'(p0)};
        prio_wr = 1'b1;
        step();
        prio_wr = 1'b0;
        step();
    endtask

    // Expect a valid completion for requester i, delta cycles after c0.
    task automatic expect_valid(input int i, input int c0, input int delta, input string rq);
        int who;
        wait_done(200, who);
        chk(who == i, rq, "completing requester", who, i);
        chk(cyc - c0 == delta, rq, "completion latency", cyc - c0, delta);
        chk(seen_res == {4'(chan_of(i)), 1'b0, ain}, rq, "valid result word",
            int'(seen_res), int'({4'(chan_of(i)), 1'b0, ain}));
    endtask

    initial begin
        #1_500_000;
        chk(1'b0, "WD", "watchdog expired at cycle", cyc, 0);
        summary();
    end

    initial begin
        int c0, who, s, ndone, r, t;
        void'($urandom(32'd20240611));
        arb_mode = 2'd0; force_sel = 2'd3; settle_cycles = 3'd2;
        prio_wdata = '0; chan_flat = {4'd9, 4'd7, 4'd3}; ain = 12'hA5C;
        do_reset();

        // R1: reset state
        chk(grant == 3'b000 && done == 3'b000, "R1", "grant/done after reset", {grant, done}, 0);
        chk(result == '0, "R1", "result after reset", int'(result), 0);
        chk(prio_cur == 6'h06, "R1", "priorities after reset", prio_cur, 6'h06);
        chk(force_vec == 3'b001, "R1", "force_vec after reset", force_vec, 1);

        // R2: illegal writes ignored, legal one accepted; R3 follows it
        write_prio(0, 1, 1);
        chk(prio_cur == 6'h06, "R2", "duplicate value write", prio_cur, 6'h06);
        write_prio(3, 1, 0);
        chk(prio_cur == 6'h06, "R2", "out-of-range write", prio_cur, 6'h06);
        write_prio(0, 2, 1);
        chk(prio_cur == 6'h18, "R2", "legal write", prio_cur, 6'h18);
        chk(force_vec == 3'b010, "R3", "force_vec follows top", force_vec, 2);

        // R4: new order digital above radio
        req = 3'b101; step();
        chk(grant == 3'b100, "R4", "fixed winner with new priorities", grant, 4);
        wait_done(100, who); wait_done(100, who);
        write_prio(2, 1, 0); bp[0] = 2; bp[1] = 1; bp[2] = 0;

        // R4/R9: rtc beats digital, settle 2
        req = 3'b110; c0 = cyc; step();
        chk(grant == 3'b010, "R4", "fixed winner default priorities", grant, 2);
        expect_valid(1, c0, 1 + 2 + LAT, "R9");
        c0 = cyc;
        expect_valid(2, c0, 1 + 2 + LAT, "R8");

        // R7: radio preempts a digital conversion, settle 1
        settle_cycles = 3'd1; ain = 12'h3C1;
        req = 3'b100; c0 = cyc;
        repeat (4) step();
        req[0] = 1'b1; step();
        chk(seen_done == 3'b100, "R7", "preempted owner done", seen_done, 4);
        chk(seen_res == {4'hF, 13'h0}, "R7", "invalid result word", int'(seen_res), 17'h1E000);
        chk(grant == 3'b001, "R7", "grant moved to radio", grant, 1);
        c0 = cyc;
        expect_valid(0, c0, 1 + LAT, "R7");

        // R7: lower priority does not preempt
        req = 3'b001; repeat (3) step();
        req[2] = 1'b1;
        wait_done(100, who);
        chk(who == 0 && seen_res[16:13] == 4'd3, "R7", "no preemption by lower", who, 0);
        wait_done(100, who);

        // R9: settle clamp
        settle_cycles = 3'd7; req = 3'b010; c0 = cyc;
        expect_valid(1, c0, 1 + 4 + LAT, "R9");

        // R5: rotating order after reset
        do_reset();
        arb_mode = 2'd1; settle_cycles = 3'd0; ain = 12'h777;
        req = 3'b111; c0 = cyc;
        expect_valid(0, c0, 1 + LAT, "R5");
        expect_valid(1, c0, 2 * (1 + LAT), "R5");
        expect_valid(2, c0, 3 * (1 + LAT), "R5");
        req = 3'b010; wait_done(100, who);
        req = 3'b101; wait_done(100, who);
        chk(who == 2, "R5", "rotation resumes after requester 1", who, 2);
        wait_done(100, who);
        chk(who == 0, "R5", "rotation then requester 0", who, 0);

        // R10: no preemption in rotating mode
        req = 3'b100; repeat (3) step();
        req[0] = 1'b1;
        wait_done(100, who);
        chk(who == 2 && seen_res[16:13] == 4'd9, "R10", "owner finishes valid", int'(seen_res[16:13]), 9);
        wait_done(100, who);

        // R6: shield mode
        arb_mode = 2'd2; force_sel = 2'd1; req = 3'b101; ndone = 0; t = 0;
        for (int n = 0; n < 20; n++) begin
            step();
            if (|seen_done) ndone++;
            if (grant != 3'b000) t++;
        end
        chk(ndone == 0 && t == 0, "R6", "unforced requesters ignored", ndone + t, 0);
        req[1] = 1'b1; c0 = cyc;
        expect_valid(1, c0, 1 + LAT, "R6");
        force_sel = 2'd0; step();
        chk(grant == 3'b001, "R6", "forced target switched", grant, 1);
        wait_done(100, who);
        arb_mode = 2'd0; wait_done(100, who);

        // R4/R7/R8/R11: random fixed-mode traffic
        arb_mode = 2'd0;
        for (int seg = 0; seg < 6; seg++) begin
            int p [3];
            p[0] = 0; p[1] = 1; p[2] = 2;
            for (int k = 0; k < 2; k++) begin
                r = $urandom_range(2); s = p[k]; p[k] = p[r]; p[r] = s;
            end
            write_prio(p[0], p[1], p[2]);
            bp[0] = p[0]; bp[1] = p[1]; bp[2] = p[2];
            settle_cycles = 3'($urandom_range(5));
            ain = 12'($urandom);
            for (int n = 0; n < 2500; n++) begin
                if ($urandom_range(7) == 0) req[$urandom_range(2)] = 1'b1;
                step();
                chk($countones(grant) <= 1, "R11", "grant one-hot", grant, 0);
                for (int i = 0; i < 3; i++) begin
                    if (seen_done[i]) begin
                        if (seen_res[16:13] == 4'hF) begin
                            t = 0;
                            for (int j = 0; j < 3; j++) if (grant[j] && bp[j] > bp[i]) t = 1;
                            chk(t == 1 && seen_res[11:0] == 0, "R7", "invalid only for outranked owner",
                                int'(seen_res), 17'h1E000);
                        end else begin
                            chk(seen_res == {4'(chan_of(i)), 1'b0, ain}, "R8", "random valid word",
                                int'(seen_res), int'({4'(chan_of(i)), 1'b0, ain}));
                        end
                    end
                end
            end
            for (int n = 0; n < 400 && req != 3'b000; n++) step();
            chk(req == 3'b000, "R4", "all requests served", req, 0);
            step();
        end
        summary();
    end
endmodule